// File: doc/BRIEF.md
# Two-Phase Normalizing Unsigned Divider

This block divides one unsigned integer by another over several clock cycles and returns both the quotient and the remainder. A single-cycle start pulse captures the two operands. The block then moves through two phases. In the first, it doubles a copy of the divisor, together with a one-hot weight register, until the copy is larger than the dividend. In the second, it halves both registers on every cycle. On each of these cycles it subtracts the divisor copy from the running dividend whenever the copy fits, and adds the current weight into the quotient.

The number of cycles depends on the operands. Small quotients finish sooner than large ones. A zero divisor skips both phases: the block returns at once with a flag set, an all-ones quotient and the dividend as the remainder. Results stay on the outputs after the completion pulse until the next accepted start.

Top module: `norm_divider`

## Requirements
- R1: After reset, done, div_zero, quotient and remainder are all 0.
- R2: For a nonzero divisor d and dividend n, the result is quotient = floor(n/d) and remainder = n - quotient*d. For example, 94 divided by 7 gives 13 remainder 3.
- R3: Let k be the smallest count of doublings with d*2^k > n. The done output is high exactly on the cycle after the 2k+2-th rising edge that follows the edge sampling start, and only for that one cycle.
- R4: When the dividend is smaller than the divisor (k = 0), the result is quotient 0 and remainder = dividend, and done comes after 2 edges.
- R5: A zero divisor sets div_zero to 1, gives an all-ones quotient and remainder = dividend, and raises done on the cycle right after the start edge. The next start with a nonzero divisor clears div_zero to 0.
- R6: A dividend with its top bit set is divided correctly without overflow, including by a divisor of 1 (quotient = dividend, k = WIDTH).
- R7: A start pulse that arrives while a division is in progress is ignored. The running division finishes with its own operands and its own timing.
- R8: After done, quotient, remainder and div_zero hold their values until the next accepted start.
- R9: The remainder returned for a nonzero divisor is always less than that divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request; operands are captured when idle |
| dividend | input | WIDTH | Unsigned dividend |
| divisor | input | WIDTH | Unsigned divisor |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Result came from a zero divisor |
| quotient | output | WIDTH | Quotient result |
| remainder | output | WIDTH | Remainder result |

## Verification
Random divisors are drawn with a random number of significant bits. This spreads the doubling count k across its whole range, so the checks can separate a wrong stopping point in either phase from a wrong subtract decision. Directed cases cover the following:
- 94/7, whose trace is fully known.
- A divisor larger than the dividend, where phase two does no subtraction.
- A divisor equal to the dividend.
- A top-bit dividend divided by 1, the longest run, which would expose a divisor register too narrow for the last doubling.
- A zero divisor, which must bypass both phases.

A second start in the middle of a division shows whether busy operands are ignored. Re-reading the outputs several cycles after done shows whether the results are held.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ALIGN  = 2'd1,
    ST_REDUCE = 2'd2
  } ndiv_state_e;
endpackage

// File: rtl/ndiv_datapath.sv
module ndiv_datapath #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             zero_load,
  input  logic             shift_up,
  input  logic             step,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             dsr_gt_rem,
  output logic             pow_last,
  output logic [WIDTH-1:0] quo,
  output logic [WIDTH-1:0] rem
);
  localparam int XW = WIDTH + 1;

  logic [WIDTH-1:0] rem_q, rem_d, quo_q, quo_d;
  logic [XW-1:0]    dsr_q, dsr_d, pow_q, pow_d;
  logic             en;

  assign dsr_gt_rem = dsr_q > {1'b0, rem_q};
  assign pow_last   = (pow_q == XW'(1));
  assign en         = load | shift_up | step;

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    dsr_d = dsr_q;
    pow_d = pow_q;
    if (load) begin
      rem_d = dividend;
      dsr_d = {1'b0, divisor};
      pow_d = XW'(1);
      quo_d = zero_load ? {WIDTH{1'b1}} : '0;
    end else if (shift_up) begin
      dsr_d = dsr_q << 1;
      pow_d = pow_q << 1;
    end else if (step) begin
      if (!dsr_gt_rem) begin
        rem_d = rem_q - dsr_q[WIDTH-1:0];
        quo_d = quo_q | pow_q[WIDTH-1:0];
      end
      dsr_d = dsr_q >> 1;
      pow_d = pow_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      pow_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dsr_q <= dsr_d;
      pow_q <= pow_d;
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;

  // R6: the weight register never carries more than one bit
  a_r6_pow_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pow_q));

  // R6: a doubling is never applied to a divisor copy already at the top bit
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    shift_up |-> !dsr_q[WIDTH]);

  // R2: the working dividend never grows during reduction
  a_r2_rem_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> rem_q <= $past(rem_q));

  // R9: after the last reduction step the remainder is below the divisor
  a_r9_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pow_last) |=> {1'b0, rem_q} < $past(dsr_q));
endmodule

// File: rtl/ndiv_ctrl.sv
module ndiv_ctrl
  import ndiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic div_is_zero,
  input  logic dsr_gt_rem,
  input  logic pow_last,
  output logic load,
  output logic zero_load,
  output logic shift_up,
  output logic step,
  output logic done,
  output logic div_zero
);
  ndiv_state_e state_q, state_d;
  logic        done_q, done_d, dz_q, dz_d;

  always_comb begin
    state_d   = state_q;
    done_d    = 1'b0;
    dz_d      = dz_q;
    load      = 1'b0;
    zero_load = 1'b0;
    shift_up  = 1'b0;
    step      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        load = 1'b1;
        if (div_is_zero) begin
          zero_load = 1'b1;
          done_d    = 1'b1;
          dz_d      = 1'b1;
        end else begin
          dz_d    = 1'b0;
          state_d = ST_ALIGN;
        end
      end
      ST_ALIGN: begin
        if (dsr_gt_rem) state_d = ST_REDUCE;
        else            shift_up = 1'b1;
      end
      ST_REDUCE: begin
        step = 1'b1;
        if (pow_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      dz_q    <= dz_d;
    end
  end

  assign done     = done_q;
  assign div_zero = dz_q;

  // R3: done lasts one cycle unless an immediate zero-divisor start retriggers it
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(start && div_is_zero)) |=> !done_q);

  // R7: a start seen while aligning does not drop the block back to idle
  a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ALIGN && start) |=> state_q != ST_IDLE);

  // R8: the zero-divisor flag only moves on an accepted start
  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_q == ST_IDLE && start) |=> $stable(dz_q));
endmodule

// File: rtl/norm_divider.sv
module norm_divider #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             done,
  output logic             div_zero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       load, zero_load, shift_up, step, dsr_gt_rem, pow_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ndiv_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .div_is_zero(divisor == '0),
    .dsr_gt_rem (dsr_gt_rem),
    .pow_last   (pow_last),
    .load       (load),
    .zero_load  (zero_load),
    .shift_up   (shift_up),
    .step       (step),
    .done       (done),
    .div_zero   (div_zero)
  );

  ndiv_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (load),
    .zero_load (zero_load),
    .shift_up  (shift_up),
    .step      (step),
    .dividend  (dividend),
    .divisor   (divisor),
    .dsr_gt_rem(dsr_gt_rem),
    .pow_last  (pow_last),
    .quo       (quotient),
    .rem       (remainder)
  );
endmodule

// File: tb/tb_norm_divider.sv
module tb_norm_divider;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic         done, div_zero;
  logic [W-1:0] quotient, remainder;

  int tests = 0;
  int fails = 0;

  norm_divider #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .done(done), .div_zero(div_zero),
    .quotient(quotient), .remainder(remainder)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [W-1:0] n, input logic [W-1:0] d);
    int k = 0;
    if (d == 0) return 0;
    while ((longint'(d) << k) <= longint'(n)) k++;
    return 2 * k + 2;
  endfunction

  task automatic pulse_start(input logic [W-1:0] n, input logic [W-1:0] d);
    @(negedge clk);
    start = 1'b1; dividend = n; divisor = d;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cnt);
    cnt = 0;
    while (!done && cnt < 300) begin
      @(posedge clk); cnt++; @(negedge clk);
    end
  endtask

  task automatic run(input logic [W-1:0] n, input logic [W-1:0] d, input string tag, input bit hold_chk);
    int cnt;
    logic [W-1:0] eq, er;
    pulse_start(n, d);
    wait_done(cnt);
    eq = (d == 0) ? {W{1'b1}} : n / d;
    er = (d == 0) ? n : n % d;
    check(cnt == exp_lat(n, d), {tag, " R3 latency"}, cnt, exp_lat(n, d));
    check(quotient == eq, {tag, " R2 quotient"}, quotient, eq);
    check(remainder == er, {tag, " R2 remainder"}, remainder, er);
    check(div_zero == (d == 0), {tag, " R5 div_zero"}, div_zero, d == 0);
    if (d != 0) check(remainder < d, {tag, " R9 rem<div"}, remainder, d);
    @(negedge clk);
    check(done == 1'b0, {tag, " R3 done pulse"}, done, 0);
    if (hold_chk) begin
      repeat (3) @(negedge clk);
      check(quotient == eq && remainder == er && div_zero == (d == 0),
            {tag, " R8 hold"}, quotient, eq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    int cnt;
    unused_seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(done == 0 && div_zero == 0, "R1 flags", {done, div_zero}, 0);
    check(quotient == 0 && remainder == 0, "R1 results", quotient, 0);

    run(16'd94, 16'd7, "R2 94/7", 1'b1);
    run(16'd5, 16'd9, "R4 small", 1'b1);
    run(16'd0, 16'd3, "R4 zero dividend", 1'b0);
    run(16'd77, 16'd77, "R2 equal", 1'b0);
    run(16'hFFFF, 16'd1, "R6 max/1", 1'b1);
    run(16'h8001, 16'h8000, "R6 top bits", 1'b0);
    run(16'h1234, 16'd0, "R5 zero div", 1'b1);
    run(16'd100, 16'd10, "R5 clear", 1'b0);
    run(16'hFFFF, 16'hFFFF, "R6 max/max", 1'b0);

    // R7: second start mid-run is ignored
    pulse_start(16'd1000, 16'd3);
    @(negedge clk);
    start = 1'b1; dividend = 16'd50; divisor = 16'd0;
    @(negedge clk);
    start = 1'b0;
    wait_done(cnt);
    check(cnt + 2 == exp_lat(16'd1000, 16'd3), "R7 latency", cnt + 2, exp_lat(16'd1000, 16'd3));
    check(quotient == 16'd333 && remainder == 16'd1, "R7 quotient", quotient, 333);
    check(div_zero == 0, "R7 div_zero", div_zero, 0);
    @(negedge clk);

    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] n, d;
      n = W'($urandom);
      d = W'($urandom & ((32'd1 << ($urandom % 17)) - 1));
      run(n, d, "R2 random", i % 16 == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule